// File: doc/BRIEF.md
# Three-Wire Nibble Register Serial Slave

This block is the slave side of a three-signal serial link. Through it an external host reaches a register file of sixteen 4-bit entries. The host raises a chip enable and clocks 8-bit frames in on a shift clock. Each frame opens with a 4-bit control field and closes with a 4-bit payload, both sent most significant bit first. The first control bit is a don't-care. The other three control bits, taken in the order read/write, address and data, choose what the frame does: load the address register, write the payload into the addressed entry, read the addressed entry back, or stop.

The block samples its three inputs with its own system clock. They pass through a synchronizer, and the block detects edges of the shift clock itself, so the shift clock has to run well below the system clock. The host may send frames back to back for as long as the chip enable stays high. A stop frame blocks every later frame until the enable is released. Dropping the enable at any point throws away a partly received frame. On a read frame the block drives the data line for the four payload bit times and changes the data on falling shift-clock edges. At every other time it leaves the line to the host. The pins are plain levels with no stream handshake, because the host paces all traffic through the shift clock and nothing can apply back-pressure.

Top module: `tws_nibble_slave`

## Requirements
- R1: After reset every register entry reads as 0, the address register holds 0 and `sio_oe` is 0.
- R2: `sio_in` is sampled on rising shift-clock edges. A frame with control bits read/write=0, address=1, data=0 (bits 2, 3 and 4 of the frame) loads bits 5 to 8, MSB first, into the address register.
- R3: A frame with read/write=0, address=0, data=1 writes its payload into the entry selected by the address register. The write takes effect on the eighth rising edge of that frame.
- R4: A frame with read/write=1 and address=0 (data bit ignored) drives `sio_oe`=1 and sends the addressed entry MSB first. Its first bit follows the falling edge after the fourth rising edge, and each later bit follows the next falling edge. `sio_oe` returns to 0 on the falling edge after the eighth rising edge.
- R5: `sio_oe` stays 0 during every control field and for all of every frame that is not a read.
- R6: Frames run back to back while the chip enable is high. The next frame's first bit comes on the rising edge right after the previous frame's eighth edge, and a read may follow a write within the same enable period.
- R7: A frame with read/write, address and data all 0 ends the operation. Until the chip enable goes low, later frames change no entry and no address, and they do not drive the line.
- R8: Taking the chip enable low discards a partial frame, so no write happens. The next enable period counts frame bits from the start again.
- R9: The control codes read/write=0, address=1, data=1 and read/write=1, address=1 change no entry, change no address and leave `sio_oe` at 0.
- R10: The value of the first control bit has no effect on decoding.
- R11: The address register keeps its value from one enable period to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce | input | 1 | Chip enable from the host; high frames a transaction |
| sclk | input | 1 | Shift clock from the host |
| sio_in | input | 1 | Data line as seen at the pin |
| sio_out | output | 1 | Data the block places on the line during reads |
| sio_oe | output | 1 | High when the block drives the data line |

## Verification
The main function is tried with isolated transactions, one enable period per access, which check address loading, writes and MSB-first read-back for distinct nibble values. It is then tried with long chains of frames in a single enable period, which separate correct frame chaining from a bit counter that drifts. Stop frames, enables dropped in mid-frame, and the unused control codes show that blocked or partial frames leave both the entries and the address untouched. A set first control bit shows that decoding ignores that bit, and reads without a fresh address frame show that the address register keeps its value.

// File: rtl/tws_pkg.sv
package tws_pkg;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_ADDR  = 3'd1,
    OP_WRITE = 3'd2,
    OP_READ  = 3'd3,
    OP_STOP  = 3'd4
  } op_e;

  function automatic op_e decode_ctrl(logic rw, logic ad, logic dt);
    if (rw) return ad ? OP_NONE : OP_READ;
    if (ad) return dt ? OP_NONE : OP_ADDR;
    return dt ? OP_WRITE : OP_STOP;
  endfunction

endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
  parameter int STAGES = 2,
  parameter int W      = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] st;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) st[0] <= '0;
          else        st[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) st[i] <= '0;
          else        st[i] <= st[i-1];
        end
      end
    end
  endgenerate

  assign q = st[STAGES-1];
endmodule

// File: rtl/tws_regfile.sv
module tws_regfile #(
  parameter int PAY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PAY_W-1:0] wr_addr,
  input  logic [PAY_W-1:0] wr_data,
  input  logic [PAY_W-1:0] rd_addr,
  output logic [PAY_W-1:0] rd_data
);
  localparam int DEPTH = 1 << PAY_W;

  logic [DEPTH-1:0][PAY_W-1:0] mem;

  genvar i;
  generate
    for (i = 0; i < DEPTH; i++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                    mem[i] <= '0;
        else if (wr_en && (wr_addr == PAY_W'(i)))      mem[i] <= wr_data;
      end
    end
  endgenerate

  assign rd_data = mem[rd_addr];

  // R3: contents change only through a write strobe
  p_hold_unless_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mem));

endmodule

// File: rtl/tws_frame.sv
module tws_frame
  import tws_pkg::*;
#(
  parameter int PAY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_s,
  input  logic             sclk_s,
  input  logic             sio_s,
  input  logic [PAY_W-1:0] rd_data,
  output logic [PAY_W-1:0] addr,
  output logic             wr_en,
  output logic [PAY_W-1:0] wr_data,
  output logic             sio_out,
  output logic             sio_oe
);
  localparam int CTRL_W    = 4;
  localparam int FRAME_LEN = CTRL_W + PAY_W;
  localparam int CNT_W     = $clog2(FRAME_LEN);
  localparam int SH_W      = PAY_W - 1;
  localparam logic [CNT_W-1:0] LAST     = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] CTRL_END = CNT_W'(CTRL_W - 1);
  localparam logic [CNT_W-1:0] PAY_BEG  = CNT_W'(CTRL_W);

  logic             sclk_d;
  logic             rise, fall;
  logic [CNT_W-1:0] cnt;
  logic [SH_W-1:0]  shreg;
  op_e              op, op_new;
  logic             stopped;
  logic [PAY_W-1:0] rsh;
  logic             frame_end, in_payload;

  assign rise       = ce_s &  sclk_s & ~sclk_d;
  assign fall       = ce_s & ~sclk_s &  sclk_d;
  assign op_new     = decode_ctrl(shreg[1], shreg[0], sio_s);
  assign frame_end  = rise && (cnt == LAST) && !stopped;
  assign in_payload = (cnt >= PAY_BEG);
  assign wr_data    = {shreg, sio_s};
  assign wr_en      = frame_end && (op == OP_WRITE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      shreg   <= '0;
      op      <= OP_NONE;
      stopped <= 1'b0;
      addr    <= '0;
      rsh     <= '0;
      sio_out <= 1'b0;
      sio_oe  <= 1'b0;
    end else if (!ce_s) begin
      cnt     <= '0;
      op      <= OP_NONE;
      stopped <= 1'b0;
      sio_oe  <= 1'b0;
    end else if (rise) begin
      shreg <= {shreg[SH_W-2:0], sio_s};
      cnt   <= (cnt == LAST) ? '0 : cnt + 1'b1;
      if (cnt == CTRL_END) begin
        op <= op_new;
        if (op_new == OP_STOP) stopped <= 1'b1;
      end
      if (frame_end && (op == OP_ADDR)) addr <= wr_data;
    end else if (fall) begin
      if (in_payload && (op == OP_READ) && !stopped) begin
        sio_oe <= 1'b1;
        if (cnt == PAY_BEG) begin
          sio_out <= rd_data[PAY_W-1];
          rsh     <= rd_data << 1;
        end else begin
          sio_out <= rsh[PAY_W-1];
          rsh     <= rsh << 1;
        end
      end else begin
        sio_oe <= 1'b0;
      end
    end
  end

  // R8: releasing the enable frees the line and restarts the bit count
  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_s |=> (!sio_oe && cnt == '0));

  // R4: the line is driven only inside an unblocked read frame
  p_drive_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sio_oe |-> (op == OP_READ && !stopped && ce_s));

  // R4: driven data changes only after a falling shift-clock edge
  p_fall_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sio_oe && !$stable(sio_out)) |-> $past(fall));

  // R2: bit count advances only on sampled rising edges
  p_cnt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_s && !rise) |=> $stable(cnt));

  // R7: a stop persists while the enable is held
  p_stop_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped && ce_s) |=> stopped);

endmodule

// File: rtl/tws_nibble_slave.sv
module tws_nibble_slave #(
  parameter int PAY_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce,
  input  logic sclk,
  input  logic sio_in,
  output logic sio_out,
  output logic sio_oe
);
  logic [2:0]       pins_s;
  logic [PAY_W-1:0] addr, wr_data, rd_data;
  logic             wr_en;

  tws_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({ce, sclk, sio_in}),
    .q     (pins_s)
  );

  tws_frame #(.PAY_W(PAY_W)) u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_s    (pins_s[2]),
    .sclk_s  (pins_s[1]),
    .sio_s   (pins_s[0]),
    .rd_data (rd_data),
    .addr    (addr),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .sio_out (sio_out),
    .sio_oe  (sio_oe)
  );

  tws_regfile #(.PAY_W(PAY_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (addr),
    .wr_data (wr_data),
    .rd_addr (addr),
    .rd_data (rd_data)
  );
endmodule

// File: tb/tws_nibble_slave_test.sv
`timescale 1ns/1ps
module tws_nibble_slave_test;
  logic clk = 0, rst_n = 0, ce = 0, sclk = 0, host_sio = 0;
  logic sio_out, sio_oe;
  wire  bus = sio_oe ? sio_out : host_sio;
  int   vectors = 0, misses = 0;
  bit   done = 0;

  always #4 clk = ~clk;

  tws_nibble_slave uut (.clk(clk), .rst_n(rst_n), .ce(ce), .sclk(sclk),
    .sio_in(bus), .sio_out(sio_out), .sio_oe(sio_oe));

  localparam logic [2:0] C_ADDR = 3'b010, C_WR = 3'b001, C_RD = 3'b100,
                         C_STOP = 3'b000, C_U1 = 3'b011, C_U2 = 3'b110, C_U3 = 3'b111;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ce_up;  @(negedge clk); ce = 1; idle(4); endtask
  task automatic ce_dn;  @(negedge clk); ce = 0; idle(6); endtask

  // one frame; nbits < 8 stops early; rd = line at bits 5..8, oem = sio_oe per bit
  task automatic frame(input logic dc, input logic [2:0] c, input logic [3:0] pay,
                       input int nbits, output logic [3:0] rd, output logic [7:0] oem);
    logic [7:0] bits;
    bits = {dc, c, pay};
    rd = 0; oem = 0;
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk); host_sio = bits[7-i];
      idle(8);
      oem[7-i] = sio_oe;
      if (i >= 4) rd[7-i] = bus;
      @(negedge clk); sclk = 1;
      idle(7);
      @(negedge clk); sclk = 0;
    end
  endtask

  task automatic write_reg(input logic [3:0] a, input logic [3:0] d);
    logic [3:0] r; logic [7:0] m;
    ce_up; frame(0, C_ADDR, a, 8, r, m); frame(0, C_WR, d, 8, r, m); ce_dn;
  endtask

  task automatic read_reg(input logic [3:0] a, output logic [3:0] d);
    logic [7:0] m;
    ce_up; frame(0, C_ADDR, a, 8, d, m); frame(0, C_RD, 4'h0, 8, d, m); ce_dn;
  endtask

  task automatic t_reset;
    logic [3:0] d; logic [7:0] m;
    check(sio_oe == 0, "R1 oe", sio_oe, 0);
    ce_up; frame(0, C_RD, 4'h0, 8, d, m); ce_dn;
    check(d == 0, "R1 addr0 readback", d, 0);
    for (int a = 0; a < 16; a++) begin
      read_reg(4'(a), d);
      check(d == 0, "R1 entry zero", d, 0);
    end
  endtask

  task automatic t_basic;
    logic [3:0] d, r; logic [7:0] m;
    ce_up; frame(0, C_ADDR, 4'hA, 8, r, m);
    check(m == 0, "R5 oe in addr frame", m, 0);
    frame(0, C_WR, 4'h5, 8, r, m);
    check(m == 0, "R5 oe in write frame", m, 0);
    ce_dn;
    write_reg(4'h3, 4'hC);
    ce_up; frame(0, C_ADDR, 4'hA, 8, r, m); frame(0, C_RD, 4'h0, 8, d, m);
    check(m == 8'h0F, "R4 oe only in payload", m, 8'h0F);
    check(d == 4'h5, "R2 R3 R4 readback A", d, 4'h5);
    idle(10);
    check(sio_oe == 0, "R4 release after frame", sio_oe, 0);
    ce_dn;
    read_reg(4'h3, d);
    check(d == 4'hC, "R3 readback 3", d, 4'hC);
    ce_up; frame(0, C_ADDR, 4'h3, 8, r, m); frame(0, 3'b101, 4'h0, 8, d, m); ce_dn;
    check(d == 4'hC, "R4 read with data bit set", d, 4'hC);
  endtask

  task automatic t_b2b;
    logic [3:0] d, r; logic [7:0] m;
    ce_up;
    frame(0, C_ADDR, 4'h4, 8, r, m); frame(0, C_WR, 4'h9, 8, r, m);
    frame(0, C_ADDR, 4'h6, 8, r, m); frame(0, C_WR, 4'h6, 8, r, m);
    frame(0, C_RD, 4'h0, 8, d, m);
    check(d == 4'h6, "R6 read after write same CE", d, 4'h6);
    frame(0, C_ADDR, 4'h4, 8, r, m); frame(0, C_RD, 4'h0, 8, d, m);
    check(d == 4'h9, "R6 chained read", d, 4'h9);
    frame(0, C_ADDR, 4'h6, 8, r, m);
    check(m == 0, "R5 oe on frame after read", m, 0);
    ce_dn;
  endtask

  task automatic t_stop;
    logic [3:0] d, r; logic [7:0] m;
    ce_up;
    frame(0, C_ADDR, 4'h7, 8, r, m); frame(0, C_WR, 4'h2, 8, r, m);
    frame(0, C_STOP, 4'hF, 8, r, m);
    frame(0, C_ADDR, 4'h8, 8, r, m); frame(0, C_WR, 4'hD, 8, r, m);
    frame(0, C_RD, 4'h0, 8, d, m);
    check(m == 0, "R7 no drive after stop", m, 0);
    frame(0, C_WR, 4'hE, 8, r, m);
    ce_dn;
    read_reg(4'h8, d);
    check(d == 4'h0, "R7 blocked write", d, 0);
    read_reg(4'h7, d);
    check(d == 4'h2, "R7 pre-stop write kept", d, 4'h2);
  endtask

  task automatic t_abort;
    logic [3:0] d, r; logic [7:0] m;
    ce_up; frame(0, C_ADDR, 4'h9, 8, r, m); frame(0, C_WR, 4'hB, 6, r, m); ce_dn;
    ce_up; frame(0, C_RD, 4'h0, 8, d, m); ce_dn;
    check(d == 4'h0, "R8 partial write discarded", d, 0);
    check(m == 8'h0F, "R8 fresh bit count", m, 8'h0F);
    write_reg(4'h9, 4'h1);
    ce_up; frame(0, C_ADDR, 4'h2, 3, r, m); ce_dn;
    ce_up; frame(0, C_RD, 4'h0, 8, d, m); ce_dn;
    check(d == 4'h1, "R11 address kept across CE", d, 4'h1);
  endtask

  task automatic t_unused;
    logic [3:0] d, r; logic [7:0] m, acc;
    write_reg(4'h2, 4'h5);
    ce_up; frame(0, C_ADDR, 4'h2, 8, r, m);
    acc = 0;
    frame(0, C_U1, 4'hF, 8, r, m); acc |= m;
    frame(0, C_U2, 4'hE, 8, r, m); acc |= m;
    frame(0, C_U3, 4'hD, 8, r, m); acc |= m;
    check(acc == 0, "R9 no drive on unused codes", acc, 0);
    frame(0, C_RD, 4'h0, 8, d, m);
    check(d == 4'h5, "R9 entry and address unchanged", d, 4'h5);
    ce_dn;
    read_reg(4'hF, d);
    check(d == 4'h0, "R9 no stray write", d, 0);
  endtask

  task automatic t_dc;
    logic [3:0] d, r; logic [7:0] m;
    ce_up; frame(1, C_ADDR, 4'hE, 8, r, m); frame(1, C_WR, 4'hC, 8, r, m);
    frame(1, C_RD, 4'h0, 8, d, m); ce_dn;
    check(d == 4'hC, "R10 first bit ignored", d, 4'hC);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  endtask

  initial begin
    idle(5); rst_n = 1; idle(5);
    t_reset; t_basic; t_b2b; t_stop; t_abort; t_unused; t_dc;
    finish_run;
  end

  initial begin
    repeat (200000) @(posedge clk);
    vectors++; misses++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    finish_run;
  end
endmodule